// File: doc/BRIEF.md
# Dual-Channel Converter Input Latch Port

This block is the digital front end of a two-channel 8-bit converter. A single shared byte-wide bus carries codes for both channels. A channel-select line picks the channel. An active-low chip select and an active-low write strobe together open a write window. All four bus inputs may change at any time, independently of the system clock. They pass through one common synchronizer stage chain, so their relative timing is kept. They are then decoded in the system clock domain.

While the write window is open, the selected channel's code register is transparent and follows the bus. The window closes when chip select or write returns high, whichever happens first. The register then keeps the last byte seen before that edge. The other channel is never disturbed. Each channel raises a one-cycle update pulse whenever its code changes.

Alongside the data path, a timing monitor measures setup, hold and write-pulse length in clock cycles against parameter limits. It raises sticky error flags, which a clear input resets.

Top module: `dual_dac_latch_port`

## Requirements
- R1: After reset both code outputs are 0x00, both update pulses are low and all three error flags are low.
- R2: With select low (0 = channel A) and both chip select and write low, the channel A code follows every change on the data bus, and the channel B code does not change.
- R3: With select high (1 = channel B) and both strobes low, the channel B code follows the data bus, and the channel A code does not change.
- R4: While chip select is high or write is high, neither code output changes, whatever the state of the data bus and the select line.
- R5: When the write window closes, the selected code keeps the byte present in the last cycle of the window. This applies whichever strobe rises first. A data change in the same cycle as the closing edge is not captured.
- R6: A data change inside an open window reaches the code output on the (SYNC_STAGES+1)-th rising clock edge after it is driven.
- R7: An update pulse lasts exactly one cycle for each change of that channel's code. Rewriting the value the channel already holds gives no pulse.
- R8: If select, chip select or data has held its current value for fewer than SETUP_CYC cycles when the window closes, the setup error flag is set. A run of exactly SETUP_CYC cycles is accepted.
- R9: The hold error flag is set in two cases. The first is a change of select in the closing cycle or in the HOLD_CYC-1 cycles after it. The second is a change of chip select in that same span, when the window was closed by write alone. Data has no hold requirement.
- R10: If the window was open for fewer than WIDTH_CYC cycles, the width error flag is set. A window of exactly WIDTH_CYC cycles is accepted.
- R11: Error flags stay set until the clear input is high at a clock edge, and clear then returns all three flags to low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Channel select, 0 = A, 1 = B (asynchronous) |
| cs_n_i | input | 1 | Chip select, active low (asynchronous) |
| wr_n_i | input | 1 | Write strobe, active low (asynchronous) |
| data_i | input | DATA_W | Shared data bus, bit 7 is the MSB |
| clr_i | input | 1 | Synchronous clear of the error flags |
| code_a_o | output | DATA_W | Channel A code |
| code_b_o | output | DATA_W | Channel B code |
| upd_a_o | output | 1 | One-cycle pulse when channel A code changes |
| upd_b_o | output | 1 | One-cycle pulse when channel B code changes |
| err_setup_o | output | 1 | Sticky setup violation flag |
| err_hold_o | output | 1 | Sticky hold violation flag |
| err_width_o | output | 1 | Sticky write-width violation flag |

## Verification
The bench builds the block with SYNC_STAGES=2, SETUP_CYC=3, HOLD_CYC=2 and WIDTH_CYC=4. With a hold of two cycles, a select change one cycle after the closing edge must be flagged, and a change two cycles after must pass. This places the edge of the hold window within reach of a directed test. The setup and width limits are each driven at exactly the limit and one cycle short of it. The two-stage chain fixes the latency check at three edges.

// File: rtl/dlp_pkg.sv
package dlp_pkg;
    // Channel index carried on the select line.
    typedef enum logic {
        CH_A = 1'b0,
        CH_B = 1'b1
    } chan_sel_e;

    localparam int NUM_CH = 2;
endpackage

// File: rtl/dlp_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs; all bits
// see the same delay so their relative timing is preserved.
module dlp_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dlp_mode_dec.sv
// Decodes the synchronized strobes into the write window and one
// write enable per channel.
module dlp_mode_dec #(
    parameter int NUM_CH = 2
) (
    input  logic              sel_i,
    input  logic              cs_n_i,
    input  logic              wr_n_i,
    output logic              wmode_o,
    output logic [NUM_CH-1:0] we_o
);
    always_comb begin
        wmode_o = !cs_n_i && !wr_n_i;
        for (int c = 0; c < NUM_CH; c++) begin
            we_o[c] = wmode_o && (int'(sel_i) == c);
        end
    end
endmodule

// File: rtl/dlp_chan_reg.sv
// One channel code register: transparent while enabled, holding otherwise.
module dlp_chan_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] code_o,
    output logic         upd_o
);
    typedef struct packed {
        logic [W-1:0] code;
        logic         upd;
    } reg_st_t;

    reg_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.upd = 1'b0;
        if (we_i) begin
            st_d.code = din_i;
            st_d.upd  = (din_i != st_q.code);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign code_o = st_q.code;
    assign upd_o  = st_q.upd;

    // R2 / R3: an enabled channel shows the bus value of the previous cycle.
    p_follow_bus_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> (code_o == $past(din_i)));

    // R4: without an enable the code does not move.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(code_o));

    // R7: an update pulse always accompanies a real change of the code.
    p_pulse_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        upd_o |-> (code_o != $past(code_o)));
endmodule

// File: rtl/dlp_timing_mon.sv
// Measures setup, hold and write-window length on the synchronized bus.
module dlp_timing_mon #(
    parameter int W         = 8,
    parameter int SETUP_CYC = 3,
    parameter int HOLD_CYC  = 1,
    parameter int WIDTH_CYC = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         sel_i,
    input  logic         cs_n_i,
    input  logic [W-1:0] data_i,
    input  logic         wmode_i,
    output logic         err_setup_o,
    output logic         err_hold_o,
    output logic         err_width_o
);
    localparam int LIM   = ((SETUP_CYC > WIDTH_CYC) ? SETUP_CYC : WIDTH_CYC) + 1;
    localparam int CNT_W = $clog2(LIM + 1);
    localparam int HW    = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] SETUP_L = CNT_W'(SETUP_CYC);
    localparam logic [CNT_W-1:0] WIDTH_L = CNT_W'(WIDTH_CYC);
    localparam logic [HW-1:0]    HOLD_L  = HW'(HOLD_CYC - 1);

    typedef struct packed {
        logic             prev_sel;
        logic             prev_cs_n;
        logic [W-1:0]     prev_data;
        logic [CNT_W-1:0] run_sel;
        logic [CNT_W-1:0] run_cs;
        logic [CNT_W-1:0] run_data;
        logic [CNT_W-1:0] wlen;
        logic             wmode_prev;
        logic [HW-1:0]    hold_cnt;
        logic             hold_cs;
        logic             err_setup;
        logic             err_hold;
        logic             err_width;
    } mon_st_t;

    mon_st_t st_d, st_q;

    function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] v);
        return (v == CNT_MAX) ? v : v + 1'b1;
    endfunction

    logic sel_chg, cs_chg, data_chg;
    logic end_ev, in_hold, hold_cs_act;
    logic setup_bad, hold_bad, width_bad;

    always_comb begin
        st_d = st_q;

        sel_chg  = (sel_i  != st_q.prev_sel);
        cs_chg   = (cs_n_i != st_q.prev_cs_n);
        data_chg = (data_i != st_q.prev_data);

        st_d.prev_sel  = sel_i;
        st_d.prev_cs_n = cs_n_i;
        st_d.prev_data = data_i;

        st_d.run_sel  = sel_chg  ? CNT_W'(1) : sat_inc(st_q.run_sel);
        st_d.run_cs   = cs_chg   ? CNT_W'(1) : sat_inc(st_q.run_cs);
        st_d.run_data = data_chg ? CNT_W'(1) : sat_inc(st_q.run_data);

        st_d.wlen       = wmode_i ? sat_inc(st_q.wlen) : '0;
        st_d.wmode_prev = wmode_i;

        // Closing edge: first cycle after the window.
        end_ev      = st_q.wmode_prev && !wmode_i;
        in_hold     = end_ev || (st_q.hold_cnt != '0);
        hold_cs_act = end_ev ? !cs_n_i : st_q.hold_cs;

        if (end_ev) begin
            st_d.hold_cnt = HOLD_L;
        end else if (st_q.hold_cnt != '0) begin
            st_d.hold_cnt = st_q.hold_cnt - 1'b1;
        end else begin
            st_d.hold_cnt = '0;
        end
        st_d.hold_cs = hold_cs_act;

        setup_bad = end_ev && ((st_q.run_sel  < SETUP_L) ||
                               (st_q.run_cs   < SETUP_L) ||
                               (st_q.run_data < SETUP_L));
        hold_bad  = in_hold && (sel_chg || (hold_cs_act && cs_chg));
        width_bad = end_ev && (st_q.wlen < WIDTH_L);

        if (clr_i) begin
            st_d.err_setup = 1'b0;
            st_d.err_hold  = 1'b0;
            st_d.err_width = 1'b0;
        end
        st_d.err_setup = st_d.err_setup | setup_bad;
        st_d.err_hold  = st_d.err_hold  | hold_bad;
        st_d.err_width = st_d.err_width | width_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.prev_cs_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_setup_o = st_q.err_setup;
    assign err_hold_o  = st_q.err_hold;
    assign err_width_o = st_q.err_width;

    // R11: flags are sticky until cleared.
    p_setup_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_setup_o && !clr_i) |=> err_setup_o);
    p_hold_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_hold_o && !clr_i) |=> err_hold_o);
    p_width_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (err_width_o && !clr_i) |=> err_width_o);

    // R10: a window that stays open past the limit never raises width error.
    p_long_window_ok_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_width_o && !wmode_i && $past(wmode_i) && (st_q.wlen >= WIDTH_L))
        |=> !err_width_o);
endmodule

// File: rtl/dual_dac_latch_port.sv
module dual_dac_latch_port #(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int SETUP_CYC   = 3,
    parameter int HOLD_CYC    = 1,
    parameter int WIDTH_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              cs_n_i,
    input  logic              wr_n_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              clr_i,
    output logic [DATA_W-1:0] code_a_o,
    output logic [DATA_W-1:0] code_b_o,
    output logic              upd_a_o,
    output logic              upd_b_o,
    output logic              err_setup_o,
    output logic              err_hold_o,
    output logic              err_width_o
);
    import dlp_pkg::*;

    localparam int BW = DATA_W + 3;
    localparam logic [BW-1:0] BUS_RST = {1'b0, 1'b1, 1'b1, {DATA_W{1'b0}}};

    logic [BW-1:0]     bus_raw, bus_s;
    logic              sel_s, cs_n_s, wr_n_s;
    logic [DATA_W-1:0] data_s;
    logic              wmode;
    logic [NUM_CH-1:0] we;

    logic [NUM_CH-1:0][DATA_W-1:0] code_arr;
    logic [NUM_CH-1:0]             upd_arr;

    assign bus_raw = {sel_i, cs_n_i, wr_n_i, data_i};

    dlp_sync #(
        .W       (BW),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUS_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (bus_raw),
        .q_o   (bus_s)
    );

    assign {sel_s, cs_n_s, wr_n_s, data_s} = bus_s;

    dlp_mode_dec #(
        .NUM_CH (NUM_CH)
    ) u_dec (
        .sel_i   (sel_s),
        .cs_n_i  (cs_n_s),
        .wr_n_i  (wr_n_s),
        .wmode_o (wmode),
        .we_o    (we)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        dlp_chan_reg #(
            .W (DATA_W)
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_i   (we[ch]),
            .din_i  (data_s),
            .code_o (code_arr[ch]),
            .upd_o  (upd_arr[ch])
        );
    end

    assign code_a_o = code_arr[CH_A];
    assign code_b_o = code_arr[CH_B];
    assign upd_a_o  = upd_arr[CH_A];
    assign upd_b_o  = upd_arr[CH_B];

    dlp_timing_mon #(
        .W         (DATA_W),
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC),
        .WIDTH_CYC (WIDTH_CYC)
    ) u_mon (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr_i),
        .sel_i       (sel_s),
        .cs_n_i      (cs_n_s),
        .data_i      (data_s),
        .wmode_i     (wmode),
        .err_setup_o (err_setup_o),
        .err_hold_o  (err_hold_o),
        .err_width_o (err_width_o)
    );

    // R2 / R3: the two channels are never written in the same cycle.
    p_single_writer_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(upd_a_o && upd_b_o));
endmodule

// File: tb/dual_dac_latch_port_tb.sv
module dual_dac_latch_port_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel = 1'b0;
    logic         cs_n = 1'b1;
    logic         wr_n = 1'b1;
    logic [W-1:0] data = '0;
    logic         clr = 1'b0;
    logic [W-1:0] code_a, code_b;
    logic         upd_a, upd_b, e_setup, e_hold, e_width;

    int checks = 0;
    int failures = 0;
    int ua = 0;
    int ub = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dual_dac_latch_port #(
        .DATA_W (W), .SYNC_STAGES (2), .SETUP_CYC (3), .HOLD_CYC (2), .WIDTH_CYC (4)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .sel_i (sel), .cs_n_i (cs_n), .wr_n_i (wr_n),
        .data_i (data), .clr_i (clr), .code_a_o (code_a), .code_b_o (code_b),
        .upd_a_o (upd_a), .upd_b_o (upd_b), .err_setup_o (e_setup),
        .err_hold_o (e_hold), .err_width_o (e_width)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (upd_a) ua++;
            if (upd_b) ub++;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req, input logic s, input logic h, input logic w);
        check({req, " setup flag"}, 32'(e_setup), 32'(s));
        check({req, " hold flag"},  32'(e_hold),  32'(h));
        check({req, " width flag"}, 32'(e_width), 32'(w));
    endtask

    task automatic pulse_clear();
        clr = 1'b1; step(1); clr = 1'b0; step(1);
    endtask

    task automatic t_reset();
        check("R1 code_a", 32'(code_a), 32'h0);
        check("R1 code_b", 32'(code_b), 32'h0);
        check("R1 upd", 32'({upd_a, upd_b}), 32'h0);
        check_flags("R1", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_track_a();
        int a0 = ua; int b0 = ub;
        sel = 1'b0; data = 8'h5A; cs_n = 1'b0; step(2);
        wr_n = 1'b0; step(4);
        check("R2 code_a first", 32'(code_a), 32'h5A);
        check("R2 code_b untouched", 32'(code_b), 32'h0);
        data = 8'hC3; step(4);
        check("R2 code_a tracks", 32'(code_a), 32'hC3);
        wr_n = 1'b1; step(1); data = 8'h11; step(5);
        check("R5 code_a kept after wr", 32'(code_a), 32'hC3);
        cs_n = 1'b1; step(4);
        check("R7 upd_a count", 32'(ua - a0), 32'd2);
        check("R7 upd_b count", 32'(ub - b0), 32'd0);
        check_flags("R8 clean write A", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_track_b();
        int b0 = ub;
        sel = 1'b1; data = 8'h7E; step(3);
        cs_n = 1'b0; step(1);
        wr_n = 1'b0; step(4);
        check("R3 code_b first", 32'(code_b), 32'h7E);
        data = 8'h81; step(2);
        check("R6 code_b before latency", 32'(code_b), 32'h7E);
        step(1);
        check("R6 code_b at latency", 32'(code_b), 32'h81);
        step(2); wr_n = 1'b1; step(3); cs_n = 1'b1; step(4);
        check("R3 code_a untouched", 32'(code_a), 32'hC3);
        check("R7 upd_b count", 32'(ub - b0), 32'd2);
        check_flags("R8 clean write B", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_ignore();
        int a0 = ua; int b0 = ub;
        sel = 1'b0; cs_n = 1'b1; wr_n = 1'b0; data = 8'hEE; step(5);
        check("R4 cs high code_a", 32'(code_a), 32'hC3);
        check("R4 cs high code_b", 32'(code_b), 32'h81);
        wr_n = 1'b1; cs_n = 1'b0; sel = 1'b1; data = 8'h33; step(5);
        check("R4 wr high code_a", 32'(code_a), 32'hC3);
        check("R4 wr high code_b", 32'(code_b), 32'h81);
        check("R4 no pulses", 32'((ua - a0) + (ub - b0)), 32'd0);
        cs_n = 1'b1; step(3);
    endtask

    task automatic t_cs_first();
        sel = 1'b0; data = 8'h96; step(3);
        cs_n = 1'b0; step(3);
        wr_n = 1'b0; step(5);
        check("R2 code_a written", 32'(code_a), 32'h96);
        cs_n = 1'b1; data = 8'h69; step(2);
        wr_n = 1'b1; step(4);
        check("R5 cs-first capture", 32'(code_a), 32'h96);
        check_flags("R9 cs-first no hold error", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_same_value();
        int a0 = ua;
        sel = 1'b0; data = 8'h96; cs_n = 1'b0; step(3);
        wr_n = 1'b0; step(5); wr_n = 1'b1; step(3); cs_n = 1'b1; step(4);
        check("R7 same value no pulse", 32'(ua - a0), 32'd0);
        check("R7 same value code", 32'(code_a), 32'h96);
    endtask

    task automatic t_setup();
        pulse_clear();
        sel = 1'b1; data = 8'h10; step(3);
        cs_n = 1'b0; step(3);
        wr_n = 1'b0; step(3); data = 8'h20; step(3);
        wr_n = 1'b1; step(3); cs_n = 1'b1; step(4);
        check_flags("R8 setup at limit", 1'b0, 1'b0, 1'b0);
        check("R3 code_b after limit write", 32'(code_b), 32'h20);
        cs_n = 1'b0; step(3);
        wr_n = 1'b0; step(3); data = 8'h30; step(2);
        wr_n = 1'b1; step(3); cs_n = 1'b1; step(4);
        check_flags("R8 setup short", 1'b1, 1'b0, 1'b0);
        check("R8 code_b short write", 32'(code_b), 32'h30);
    endtask

    task automatic t_clear();
        step(3);
        check("R11 setup sticky", 32'(e_setup), 32'h1);
        pulse_clear();
        check_flags("R11 cleared", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_hold();
        sel = 1'b0; data = 8'h44; step(3);
        cs_n = 1'b0; step(3);
        wr_n = 1'b0; step(5); wr_n = 1'b1; step(2);
        sel = 1'b1; step(3); cs_n = 1'b1; step(3);
        check_flags("R9 sel change outside window", 1'b0, 1'b0, 1'b0);
        data = 8'h55; cs_n = 1'b0; step(3);
        wr_n = 1'b0; step(5); wr_n = 1'b1; step(1);
        sel = 1'b0; step(3); cs_n = 1'b1; step(3);
        check_flags("R9 sel change inside window", 1'b0, 1'b1, 1'b0);
        check("R3 code_b hold test", 32'(code_b), 32'h55);
        pulse_clear();
        step(3); cs_n = 1'b0; step(3);
        wr_n = 1'b0; step(5); wr_n = 1'b1; step(1);
        cs_n = 1'b1; step(4);
        check_flags("R9 cs change after wr end", 1'b0, 1'b1, 1'b0);
        pulse_clear();
    endtask

    task automatic t_width();
        sel = 1'b0; data = 8'hA0; step(3);
        cs_n = 1'b0; step(4);
        wr_n = 1'b0; step(4); wr_n = 1'b1; step(3); cs_n = 1'b1; step(3);
        check_flags("R10 width at limit", 1'b0, 1'b0, 1'b0);
        data = 8'hA1; cs_n = 1'b0; step(4);
        wr_n = 1'b0; step(3); wr_n = 1'b1; step(3); cs_n = 1'b1; step(3);
        check_flags("R10 width short", 1'b0, 1'b0, 1'b1);
        check("R10 short write still loads", 32'(code_a), 32'hA1);
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_track_a();
        t_track_b();
        t_ignore();
        t_cs_first();
        t_same_value();
        t_setup();
        t_clear();
        t_hold();
        t_width();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule